// File: doc/BRIEF.md
# Serial Page-Program Target with In-Page Wrap

This block is the target side of a single-line serial flash interface, limited to the page-program command. A host lowers chip select and shifts in a command byte, a 24-bit start address and then any number of data bytes, most significant bit first. Bits are sampled on rising serial clock edges, so clock modes 0 and 3 both work. The block oversamples the serial pins with its own system clock. Incoming bytes go into a page-sized staging buffer. Each byte's slot is given by the low address bits, and the slot index wraps inside the page.

The array is not touched while the host is still sending. When chip select returns high after a well-formed frame, the block raises `busy` for a fixed number of cycles. During the first cycles of that window it walks the page and writes each staged slot to the array. The stored value is the bitwise AND of the old contents and the new byte. At the end of the window it pulses `wel_clr` so that the owner of the write-enable latch can drop it. Frames that are rejected, truncated or started during the busy window leave the array untouched.

Top module: `page_program_target`

## Requirements
- R1: A frame is the command byte 0x02, then three address bytes forming a 24-bit address (most significant byte first, each byte MSB first), then data bytes. Bits are sampled on rising `spi_sck` edges while `spi_cs_n` is low. Array writes land at addresses whose bits above the page index equal the captured address bits.
- R2: The command is accepted only if `wel_in` is 1 and `protect_in` is 0 when the command byte completes. A wrong command byte, a clear latch or a set protect input causes no array write and no busy period.
- R3: The first data byte goes to page slot `addr[PAGE_W-1:0]`. Each later byte goes to the next slot modulo the page size, and it never leaves the page.
- R4: When more bytes than the page size arrive, a later byte replaces the earlier one in its slot. Only the last page-size bytes reach the array, one write per slot.
- R5: No array write happens while chip select is low. Array writes occur only while `busy` is 1.
- R6: Nothing is written if chip select rises before the three address bytes and one full data byte have arrived, or if it rises with a partial data byte (1 to 7 bits) pending.
- R7: A committed slot stores old AND new, where an erased byte reads 0xFF. Slots that received no data, and all other pages, keep their contents.
- R8: After an accepted frame ends, `busy` is 1 for exactly `BUSY_CYCLES` consecutive cycles.
- R9: `wel_clr` is a one-cycle pulse in the first cycle after `busy` falls, and it occurs at no other time.
- R10: A frame whose chip select falls while `busy` is 1 is ignored entirely.
- R11: After reset, `busy`, `wel_clr` and `arr_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select; a frame ends when it rises |
| spi_mosi | input | 1 | Serial data from the host |
| wel_in | input | 1 | Write-enable latch state |
| protect_in | input | 1 | High when the array is write-protected |
| wel_clr | output | 1 | One-cycle request to clear the write-enable latch |
| busy | output | 1 | High while a commit is in progress |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | 24 | Array byte address for both the read and the write |
| arr_wdata | output | 8 | Byte to be stored (old AND new) |
| arr_rdata | input | 8 | Current array contents at `arr_addr`, combinational |

## Verification
The bench builds the block with `PAGE_W = 4`, which gives a 16-byte page, and `BUSY_CYCLES = 40`. With a page this small, all 16 start offsets can be swept. Each offset is combined with frame lengths of one byte, a few bytes, exactly a page, a page plus one, and more than two pages. This exercises every wrap point and the last-bytes-win rule. Several frames hit the same page, so the AND accumulation is seen as well. The rejection paths (latch clear, protected, wrong command, short address, missing data, partial tail, frame during busy) are each checked against a full image of the array.

// File: rtl/pp_pkg.sv
// Shared constants and types for the page-program target.
// Assumes a fixed 24-bit command address and byte-wide data.
package pp_pkg;
    localparam int CMD_AW = 24;
    localparam logic [7:0] OPC_PAGE_PROG = 8'h02;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_SKIP
    } pp_state_e;
endpackage

// File: rtl/pp_spi_rx.sv
// Oversampling serial receiver: synchronises the pins, detects rising
// serial-clock edges while selected, assembles MSB-first bytes and flags
// the end of a frame. Assumes the serial clock runs slower than clk / 3.
module pp_spi_rx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       sel,
    output logic       byte_stb,
    output logic [7:0] byte_q,
    output logic       frame_end,
    output logic       partial
);
    logic [1:0] sck_sy, cs_sy, mosi_sy;
    logic       sck_d, cs_d;
    logic [2:0] bit_cnt;
    logic [6:0] shreg;
    logic       sck_rise;

    // Two-stage synchronisers plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sy  <= 2'b00;
            cs_sy   <= 2'b11;
            mosi_sy <= 2'b00;
            sck_d   <= 1'b0;
            cs_d    <= 1'b1;
        end else begin
            sck_sy  <= {sck_sy[0], sck};
            cs_sy   <= {cs_sy[0], cs_n};
            mosi_sy <= {mosi_sy[0], mosi};
            sck_d   <= sck_sy[1];
            cs_d    <= cs_sy[1];
        end
    end

    assign sel       = ~cs_sy[1];
    assign sck_rise  = sck_sy[1] & ~sck_d & sel;
    assign frame_end = cs_sy[1] & ~cs_d;
    assign partial   = (bit_cnt != 3'd0);

    // Bit counter and shift register; cleared while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_sy[1]) begin
            bit_cnt <= 3'd0;
            shreg   <= 7'd0;
        end else if (sck_rise) begin
            bit_cnt <= bit_cnt + 3'd1;
            shreg   <= {shreg[5:0], mosi_sy[1]};
        end
    end

    // Byte strobe on the eighth bit, with the completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_stb <= 1'b0;
            byte_q   <= 8'd0;
        end else begin
            byte_stb <= sck_rise && (bit_cnt == 3'd7);
            if (sck_rise && (bit_cnt == 3'd7))
                byte_q <= {shreg, mosi_sy[1]};
        end
    end
endmodule

// File: rtl/pp_page_buf.sv
// Page staging buffer: one byte and one "received" flag per slot.
// Assumes clear and write are never requested in the same cycle.
module pp_page_buf #(
    parameter int PAGE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [7:0]        wr_data,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    localparam int PAGE_BYTES = 1 << PAGE_W;

    logic [7:0]            slot_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] vld_q;

    // Slot data: a later write to a slot replaces the earlier one.
    always_ff @(posedge clk) begin
        if (wr_en)
            slot_q[wr_idx] <= wr_data;
    end

    // Received flags: cleared at command accept, set per written slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            vld_q <= '0;
        else if (wr_en)
            vld_q[wr_idx] <= 1'b1;
    end

    assign rd_data  = slot_q[rd_idx];
    assign rd_valid = vld_q[rd_idx];
endmodule

// File: rtl/pp_commit.sv
// Commit sequencer: holds busy for BUSY_CYCLES cycles and writes each
// received slot (old AND new) during the first page-size cycles, then
// pulses wel_clr. Assumes BUSY_CYCLES >= page size and a combinational
// array read.
module pp_commit #(
    parameter int PAGE_W      = 8,
    parameter int BUSY_CYCLES = 1024
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [pp_pkg::CMD_AW-PAGE_W-1:0] page_base,
    output logic [PAGE_W-1:0]                buf_idx,
    input  logic [7:0]                       buf_data,
    input  logic                             buf_valid,
    output logic                             arr_we,
    output logic [pp_pkg::CMD_AW-1:0]        arr_addr,
    output logic [7:0]                       arr_wdata,
    input  logic [7:0]                       arr_rdata,
    output logic                             busy,
    output logic                             wel_clr
);
    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0] cnt;
    logic             scan;

    // Busy window counter and end-of-window latch-clear pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cnt     <= '0;
            wel_clr <= 1'b0;
        end else begin
            wel_clr <= 1'b0;
            if (busy) begin
                if (cnt == CNT_W'(BUSY_CYCLES - 1)) begin
                    busy    <= 1'b0;
                    cnt     <= '0;
                    wel_clr <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end
        end
    end

    // Page walk: one slot per cycle at the start of the window.
    always_comb begin
        scan      = busy && (cnt < CNT_W'(PAGE_BYTES));
        buf_idx   = cnt[PAGE_W-1:0];
        arr_we    = scan && buf_valid;
        arr_addr  = {page_base, cnt[PAGE_W-1:0]};
        arr_wdata = arr_rdata & buf_data;
    end
endmodule

// File: rtl/page_program_target.sv
// Page-program target: decodes the command, captures the address, stages
// data with in-page wrap and starts a commit on a well-formed frame end.
// Assumes wel_in and protect_in are stable around the command byte.
module page_program_target #(
    parameter int PAGE_W      = 8,
    parameter int BUSY_CYCLES = 1024
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      spi_sck,
    input  logic                      spi_cs_n,
    input  logic                      spi_mosi,
    input  logic                      wel_in,
    input  logic                      protect_in,
    output logic                      wel_clr,
    output logic                      busy,
    output logic                      arr_we,
    output logic [pp_pkg::CMD_AW-1:0] arr_addr,
    output logic [7:0]                arr_wdata,
    input  logic [7:0]                arr_rdata
);
    import pp_pkg::*;

    pp_state_e          state;
    logic [CMD_AW-1:0]  addr_q;
    logic [1:0]         abyte_cnt;
    logic               got_data;
    logic               sel, byte_stb, frame_end, partial;
    logic [7:0]         byte_q;
    logic               accept, buf_clr, buf_wr, commit_go;
    logic [PAGE_W-1:0]  rd_idx;
    logic [7:0]         rd_data;
    logic               rd_valid;

    pp_spi_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (spi_sck),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .sel       (sel),
        .byte_stb  (byte_stb),
        .byte_q    (byte_q),
        .frame_end (frame_end),
        .partial   (partial)
    );

    // Decode of command acceptance, buffer strobes and commit start.
    always_comb begin
        accept    = (state == ST_OPC) && byte_stb && (byte_q == OPC_PAGE_PROG)
                    && wel_in && !protect_in;
        buf_clr   = accept;
        buf_wr    = (state == ST_DATA) && byte_stb && !frame_end;
        commit_go = frame_end && (state == ST_DATA) && got_data && !partial;
    end

    // Frame state machine; the low address bits double as the slot index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            addr_q    <= '0;
            abyte_cnt <= 2'd0;
            got_data  <= 1'b0;
        end else if (frame_end) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (sel) state <= busy ? ST_SKIP : ST_OPC;
                ST_OPC: if (byte_stb) begin
                    state     <= accept ? ST_ADDR : ST_SKIP;
                    abyte_cnt <= 2'd0;
                end
                ST_ADDR: if (byte_stb) begin
                    addr_q    <= {addr_q[CMD_AW-9:0], byte_q};
                    abyte_cnt <= abyte_cnt + 2'd1;
                    if (abyte_cnt == 2'd2) begin
                        state    <= ST_DATA;
                        got_data <= 1'b0;
                    end
                end
                ST_DATA: if (byte_stb) begin
                    addr_q[PAGE_W-1:0] <= addr_q[PAGE_W-1:0] + 1'b1;
                    got_data           <= 1'b1;
                end
                default: state <= state;
            endcase
        end
    end

    pp_page_buf #(.PAGE_W(PAGE_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr_en    (buf_wr),
        .wr_idx   (addr_q[PAGE_W-1:0]),
        .wr_data  (byte_q),
        .rd_idx   (rd_idx),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    pp_commit #(.PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_commit (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (commit_go),
        .page_base (addr_q[CMD_AW-1:PAGE_W]),
        .buf_idx   (rd_idx),
        .buf_data  (rd_data),
        .buf_valid (rd_valid),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .arr_rdata (arr_rdata),
        .busy      (busy),
        .wel_clr   (wel_clr)
    );
endmodule

// File: rtl/pp_program_chk.sv
// Protocol checker for page_program_target, attached by bind.
module pp_program_chk #(
    parameter int PAGE_W      = 8,
    parameter int BUSY_CYCLES = 1024
) (
    input logic        clk,
    input logic        rst_n,
    input logic        spi_cs_n,
    input logic        busy,
    input logic        wel_clr,
    input logic        arr_we,
    input logic [23:0] arr_addr
);
    logic [31:0] run_len;

    // Length of the current or just-ended busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_len <= 32'd0;
        else
            run_len <= busy ? run_len + 32'd1 : 32'd0;
    end

    assert_write_in_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

    assert_commit_deselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> spi_cs_n);

    assert_single_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |-> (arr_addr[23:PAGE_W] == $past(arr_addr[23:PAGE_W])));

    assert_busy_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && run_len != 32'd0) |-> (run_len == BUSY_CYCLES));

    assert_welclr_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> wel_clr);

    assert_welclr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> (!busy && $past(busy)));
endmodule

bind page_program_target pp_program_chk #(
    .PAGE_W      (PAGE_W),
    .BUSY_CYCLES (BUSY_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .busy     (busy),
    .wel_clr  (wel_clr),
    .arr_we   (arr_we),
    .arr_addr (arr_addr)
);

// File: tb/sim_page_program_target.sv
module sim_page_program_target;
    localparam int PW   = 4;
    localparam int PB   = 1 << PW;
    localparam int BUSY = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic wel = 1'b1, prot = 1'b0;
    logic wel_clr, busy, arr_we;
    logic [23:0] arr_addr;
    logic [7:0] arr_wdata, arr_rdata;

    logic [7:0] mem [4096];
    logic [7:0] exp_mem [4096];

    int vectors = 0, fails = 0, cyc = 0;
    int writes = 0, commits = 0, welclrs = 0, last_len = 0, run = 0;
    int hi_addr_errs = 0;
    logic busy_prev = 1'b0;

    always #2 clk = ~clk;

    page_program_target #(.PAGE_W(PW), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .wel_in(wel), .protect_in(prot), .wel_clr(wel_clr), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata)
    );

    assign arr_rdata = mem[arr_addr[11:0]];

    // Array model and port monitor, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_we) begin
                mem[arr_addr[11:0]] = arr_wdata;
                writes++;
                if (arr_addr[23:12] != 12'd0) hi_addr_errs++;
            end
            if (wel_clr) welclrs++;
            if (busy) run++;
            if (busy_prev && !busy) begin
                commits++;
                last_len = run;
                run = 0;
            end
            busy_prev = busy;
        end
    end

    // Watchdog: counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 190000) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, 190000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 29 + k * 73 + 165) ^ (k * k));
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk); sck = 1'b0; mosi = b;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic frame(input logic [7:0] opc, input logic [23:0] a, input int abytes,
                         input int ndata, input int tail, input int seed);
        @(negedge clk); cs_n = 1'b0;
        repeat (4) @(negedge clk);
        send_byte(opc);
        for (int i = 0; i < abytes; i++) send_byte(a[23 - 8 * i -: 8]);
        for (int k = 0; k < ndata; k++) send_byte(pat(seed, k));
        for (int t = 0; t < tail; t++) send_bit(1'b1);
        repeat (3) @(negedge clk);
        sck = 1'b0;
        cs_n = 1'b1;
    endtask

    function automatic int mem_diff();
        for (int i = 0; i < 4096; i++) if (mem[i] !== exp_mem[i]) return i;
        return -1;
    endfunction

    // Expected effect of a good frame: last byte per slot wins, AND into array.
    function automatic void apply_model(input logic [23:0] a, input int n, input int seed);
        logic [7:0] val [PB];
        bit hit [PB];
        for (int j = 0; j < PB; j++) hit[j] = 0;
        for (int k = 0; k < n; k++) begin
            int pos = (int'(a[PW-1:0]) + k) % PB;
            val[pos] = pat(seed, k);
            hit[pos] = 1;
        end
        for (int j = 0; j < PB; j++)
            if (hit[j]) exp_mem[{a[11:PW], PW'(j)}] &= val[j];
    endfunction

    task automatic good_frame(input logic [23:0] a, input int n, input int seed);
        int w0, c0, e0, d;
        w0 = writes; c0 = commits; e0 = welclrs;
        wel = 1'b1;
        frame(8'h02, a, 3, n, 0, seed);
        check(writes == w0, "R5 no write before deselect", writes - w0, 0);
        repeat (BUSY + 20) @(negedge clk);
        apply_model(a, n, seed);
        check(commits == c0 + 1, "R1 frame committed", commits - c0, 1);
        check(last_len == BUSY, "R8 busy length", last_len, BUSY);
        check(welclrs == e0 + 1, "R9 wel_clr pulses", welclrs - e0, 1);
        check(writes - w0 == ((n < PB) ? n : PB), "R4 writes per slot", writes - w0, (n < PB) ? n : PB);
        d = mem_diff();
        check(d < 0, "R3/R7 array image", (d < 0) ? 0 : int'(mem[d]), (d < 0) ? 0 : int'(exp_mem[d]));
    endtask

    task automatic no_effect(input string req);
        int d;
        repeat (BUSY + 20) @(negedge clk);
        d = mem_diff();
        check(d < 0, req, (d < 0) ? 0 : int'(mem[d]), (d < 0) ? 0 : int'(exp_mem[d]));
    endtask

    initial begin
        int w0, c0, ns [5];
        ns[0] = 1; ns[1] = 3; ns[2] = 16; ns[3] = 17; ns[4] = 33;
        for (int i = 0; i < 4096; i++) begin mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R11 reset busy", busy, 0);
        check(wel_clr == 1'b0, "R11 reset wel_clr", wel_clr, 0);
        check(arr_we == 1'b0, "R11 reset arr_we", arr_we, 0);

        // R3 R4 R7: every start offset against several lengths, same page reused.
        for (int s = 0; s < PB; s++)
            for (int ci = 0; ci < 5; ci++)
                good_frame({12'h000, 8'(8'h80 + s), 4'(s)}, ns[ci], s * 5 + ci);
        check(hi_addr_errs == 0, "R1 upper address bits", hi_addr_errs, 0);

        // R2: latch clear.
        w0 = writes; c0 = commits;
        wel = 1'b0;
        frame(8'h02, 24'h000310, 3, 4, 0, 7);
        no_effect("R2 latch clear array");
        check(commits == c0 && writes == w0, "R2 latch clear no busy", commits - c0, 0);
        wel = 1'b1;

        // R2: protected.
        c0 = commits; prot = 1'b1;
        frame(8'h02, 24'h000320, 3, 4, 0, 8);
        no_effect("R2 protected array");
        check(commits == c0, "R2 protected no busy", commits - c0, 0);
        prot = 1'b0;

        // R2: other command byte.
        c0 = commits;
        frame(8'h03, 24'h000330, 3, 4, 0, 9);
        no_effect("R2 wrong command array");
        check(commits == c0, "R2 wrong command no busy", commits - c0, 0);

        // R6: address cut short, no data, partial trailing byte.
        c0 = commits;
        frame(8'h02, 24'h000340, 2, 0, 0, 10);
        no_effect("R6 short address array");
        check(commits == c0, "R6 short address no busy", commits - c0, 0);
        frame(8'h02, 24'h000350, 3, 0, 0, 11);
        no_effect("R6 no data array");
        check(commits == c0, "R6 no data no busy", commits - c0, 0);
        frame(8'h02, 24'h000360, 3, 5, 3, 12);
        no_effect("R6 partial byte array");
        check(commits == c0, "R6 partial byte no busy", commits - c0, 0);

        // R6 boundary: exactly one full data byte commits.
        good_frame(24'h00037F, 1, 13);

        // R10: a frame started inside the busy window is ignored.
        c0 = commits;
        wel = 1'b1;
        frame(8'h02, 24'h000385, 3, 2, 0, 14);
        repeat (10) @(negedge clk);
        check(busy == 1'b1, "R10 busy before second frame", busy, 1);
        frame(8'h02, 24'h000395, 3, 2, 0, 15);
        repeat (BUSY + 20) @(negedge clk);
        apply_model(24'h000385, 2, 14);
        check(commits == c0 + 1, "R10 only first frame commits", commits - c0, 1);
        no_effect("R10 array image");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule